// File: doc/BRIEF.md
# Two-Engine ADC Register Front End

This block is the register-mapped control side of an analog-to-digital converter. The converter has two conversion engines. The auxiliary engine measures one of two general-purpose inputs. The battery engine measures a supply input in either a high or a low reference range. Software reaches the block through a simple byte-addressed register bus. It programs the input and range selection, then launches a conversion by setting a per-engine start bit. The hardware clears that bit again once the result has been captured, so the same bit also serves as a busy flag.

Only one physical converter sits behind both engines. The block therefore serialises requests and drives the converter with a one-cycle start pulse plus a channel code and a range flag, all held steady until the converter reports done. Each finished conversion latches its sample into the result register of its engine and raises a per-engine done flag. A done flag whose mask bit is cleared drives the interrupt output. A power-down control bit is passed out to the analog side and holds back any new conversion while it is set.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset, the enable register (offset 0x00), config (0x04) and status (0x0C) read 0, the interrupt mask (0x08) reads 0xFF, both result registers (battery 0x1C, auxiliary 0x20) read 0, and `irq` and `powerDown` are low.
- R2: Writing 1 to enable bit 0 (auxiliary) or bit 1 (battery) requests a conversion. The bit reads 1 until that engine's result is captured and then reads 0. Writing 0 to a bit that is set does not cancel the request.
- R3: Each conversion produces exactly one single-cycle `convStart` pulse. `convSel` is 0 for the first auxiliary input, 1 for the second auxiliary input and 2 for the battery. For auxiliary conversions, config bits 1:0 equal to 1 select the second input and any other value selects the first.
- R4: During a battery conversion, `convLowRange` equals config bit 4 (1 = low reference range). During an auxiliary conversion it is 0.
- R5: At most one conversion is outstanding at a time. When both start bits are pending, the auxiliary conversion is issued first and the battery conversion follows after it completes.
- R6: `convSel` and `convLowRange` are fixed when `convStart` is issued and stay stable until done. A config write during a conversion affects only later conversions.
- R7: On `convDone`, `convResult` is stored in the active engine's result register. Bits 15:12 of each result register read as 0, and a result register keeps its value until its own engine completes again.
- R8: Status bit 0 (auxiliary) or bit 1 (battery) sets when that engine's result is captured. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when some status bit is set while the mask bit at the same position (0x08, bit 0 auxiliary, bit 1 battery) is 0. A mask of 0xFF keeps `irq` low.
- R10: Enable bit 7 drives `powerDown`. While it is set no conversion starts and pending start bits stay set. Once it is cleared, the pending conversions run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for `busAddr` (combinational) |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convSel | output | 2 | Channel code: 0 aux first input, 1 aux second input, 2 battery |
| convLowRange | output | 1 | Low reference range for the battery conversion |
| convDone | input | 1 | Converter finished, result valid this cycle |
| convResult | input | RES_W | Converter sample |
| irq | output | 1 | Unmasked done interrupt |
| powerDown | output | 1 | Power-down request to the analog side |

## Verification
The converter is driven through single requests on each engine under every config select value, so a wrong input code or range flag shows up against the expected channel code. A combined request on both engines checks the ordering. A long conversion with a config rewrite and an enable write of 0 in the middle separates sampling at launch from live decoding, and shows that a request cannot be cancelled. A full-scale sample followed by a conversion on the other engine separates correct zero-padding and per-engine holding from cross-writes. Status clears, mask patterns and a power-down window then exercise the interrupt and hold-off paths.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int NUM_ENG = 2;
  localparam int ENG_AUX = 0;
  localparam int ENG_BAT = 1;

  // register byte offsets
  localparam int OFS_ENABLE = 'h00;
  localparam int OFS_CONFIG = 'h04;
  localparam int OFS_MASK   = 'h08;
  localparam int OFS_STATUS = 'h0C;
  localparam int OFS_BATRES = 'h1C;
  localparam int OFS_AUXRES = 'h20;

  localparam int BIT_PWRDN   = 7;
  localparam int CFG_LOW_BIT = 4;
  localparam int REG8_W      = 8;

  typedef enum logic [1:0] {
    SEL_AUX_A = 2'd0,
    SEL_AUX_B = 2'd1,
    SEL_BATT  = 2'd2
  } convSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_ENG-1:0] capture;
  } dpStrobe_t;
endpackage

// File: rtl/adc_ctrl_dp.sv
module adc_ctrl_dp
  import adc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int RES_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  dpStrobe_t          strobe,
  input  logic [RES_W-1:0]   capResult,
  output logic [NUM_ENG-1:0] startBits,
  output logic               powerDown,
  output logic               auxSelB,
  output logic               battLow,
  output logic [NUM_ENG-1:0] statusBits,
  output logic [NUM_ENG-1:0] maskBits,
  output logic               irq
);
  localparam int PAD_W = BIT_PWRDN - NUM_ENG;

  logic [NUM_ENG-1:0] startQ, statusQ;
  logic               pdQ, cfgLowQ;
  logic [1:0]         cfgSelQ;
  logic [REG8_W-1:0]  maskQ;
  logic [RES_W-1:0]   resQ [NUM_ENG];

  logic wrEnable, wrConfig, wrMask, wrStatus;
  assign wrEnable = busWe && (busAddr == ADDR_W'(OFS_ENABLE));
  assign wrConfig = busWe && (busAddr == ADDR_W'(OFS_CONFIG));
  assign wrMask   = busWe && (busAddr == ADDR_W'(OFS_MASK));
  assign wrStatus = busWe && (busAddr == ADDR_W'(OFS_STATUS));

  logic unusedWdata;
  assign unusedWdata = ^busWdata[DATA_W-1:REG8_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ  <= '0;
      pdQ     <= 1'b0;
      cfgSelQ <= '0;
      cfgLowQ <= 1'b0;
      maskQ   <= '1;
      statusQ <= '0;
    end else begin
      startQ  <= (startQ & ~strobe.capture)
               | (wrEnable ? busWdata[NUM_ENG-1:0] : '0);
      statusQ <= (statusQ & ~(wrStatus ? busWdata[NUM_ENG-1:0] : '0))
               | strobe.capture;
      if (wrEnable) pdQ <= busWdata[BIT_PWRDN];
      if (wrConfig) begin
        cfgSelQ <= busWdata[1:0];
        cfgLowQ <= busWdata[CFG_LOW_BIT];
      end
      if (wrMask) maskQ <= busWdata[REG8_W-1:0];
    end
  end

  // one result register per engine
  for (genvar e = 0; e < NUM_ENG; e++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rstN)                   resQ[e] <= '0;
      else if (strobe.capture[e])  resQ[e] <= capResult;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFS_ENABLE): busRdata = DATA_W'({pdQ, {PAD_W{1'b0}}, startQ});
      ADDR_W'(OFS_CONFIG): busRdata = DATA_W'({3'b000, cfgLowQ, 2'b00, cfgSelQ});
      ADDR_W'(OFS_MASK):   busRdata = DATA_W'(maskQ);
      ADDR_W'(OFS_STATUS): busRdata = DATA_W'(statusQ);
      ADDR_W'(OFS_BATRES): busRdata = DATA_W'(resQ[ENG_BAT]);
      ADDR_W'(OFS_AUXRES): busRdata = DATA_W'(resQ[ENG_AUX]);
      default:             busRdata = '0;
    endcase
  end

  assign startBits  = startQ;
  assign powerDown  = pdQ;
  assign auxSelB    = (cfgSelQ == 2'd1);
  assign battLow    = cfgLowQ;
  assign statusBits = statusQ;
  assign maskBits   = maskQ[NUM_ENG-1:0];
  assign irq        = |(statusQ & ~maskQ[NUM_ENG-1:0]);
endmodule

// File: rtl/adc_ctrl_fsm.sv
module adc_ctrl_fsm
  import adc_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_ENG-1:0] startBits,
  input  logic               powerDown,
  input  logic               auxSelB,
  input  logic               battLow,
  input  logic               convDone,
  output logic               convStart,
  output logic [1:0]         convSel,
  output logic               convLowRange,
  output dpStrobe_t          strobe
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e stQ;
  logic   battActQ;
  logic   launch, finish;

  assign launch = (stQ == ST_IDLE) && !powerDown && (|startBits);
  assign finish = (stQ == ST_WAIT) && convDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ          <= ST_IDLE;
      battActQ     <= 1'b0;
      convStart    <= 1'b0;
      convSel      <= SEL_AUX_A;
      convLowRange <= 1'b0;
    end else begin
      convStart <= launch;
      if (launch) begin
        stQ      <= ST_WAIT;
        battActQ <= !startBits[ENG_AUX];
        if (startBits[ENG_AUX]) begin
          convSel      <= auxSelB ? SEL_AUX_B : SEL_AUX_A;
          convLowRange <= 1'b0;
        end else begin
          convSel      <= SEL_BATT;
          convLowRange <= battLow;
        end
      end else if (finish) begin
        stQ <= ST_IDLE;
      end
    end
  end

  always_comb begin
    strobe.capture = '0;
    if (finish) strobe.capture = NUM_ENG'(1) << (battActQ ? ENG_BAT : ENG_AUX);
  end
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              convStart,
  output logic [1:0]        convSel,
  output logic              convLowRange,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic              irq,
  output logic              powerDown
);
  dpStrobe_t          strobe;
  logic [NUM_ENG-1:0] startBits, statusBits, maskBits;
  logic               auxSelB, battLow;

  adc_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .strobe(strobe), .capResult(convResult),
    .startBits(startBits), .powerDown(powerDown),
    .auxSelB(auxSelB), .battLow(battLow),
    .statusBits(statusBits), .maskBits(maskBits), .irq(irq)
  );

  adc_ctrl_fsm u_fsm (
    .clk(clk), .rstN(rstN),
    .startBits(startBits), .powerDown(powerDown),
    .auxSelB(auxSelB), .battLow(battLow), .convDone(convDone),
    .convStart(convStart), .convSel(convSel), .convLowRange(convLowRange),
    .strobe(strobe)
  );
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       convStart,
  input logic [1:0] convSel,
  input logic       convLowRange,
  input logic       convDone,
  input logic       powerDown,
  input logic       irq,
  input logic [1:0] statusBits
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rstN)          outstanding <= 1'b0;
    else if (convStart) outstanding <= 1'b1;
    else if (convDone)  outstanding <= 1'b0;
  end

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  p_single_outstanding_r5: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !convStart);

  p_select_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> ($stable(convSel) && $stable(convLowRange)));

  p_done_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outstanding && convDone) |=> (statusBits != 2'b00));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusBits != 2'b00));

  p_pd_holdoff_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(powerDown) |-> !convStart);
endmodule

bind adc_ctrl_regs adc_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN),
  .convStart(convStart), .convSel(convSel), .convLowRange(convLowRange),
  .convDone(convDone), .powerDown(powerDown), .irq(irq),
  .statusBits(statusBits)
);

// File: tb/sim_adc_ctrl_regs.sv
`timescale 1ns/1ps
module sim_adc_ctrl_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        convStart, convLowRange, irq, powerDown;
  logic [1:0]  convSel;
  logic        convDone = 1'b0;
  logic [11:0] convResult = '0;

  always #2.5 clk = ~clk;

  adc_ctrl_regs u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .convStart(convStart),
    .convSel(convSel), .convLowRange(convLowRange), .convDone(convDone),
    .convResult(convResult), .irq(irq), .powerDown(powerDown)
  );

  typedef struct { logic [1:0] sel; logic low; } expItem_t;
  expItem_t expQ[$];

  int nChk = 0, nBad = 0;
  int stubLat = 4, startCnt = 0, stubCnt = 0;
  logic        forceEn = 1'b0;
  logic [11:0] forceVal = '0, lastAux = '0, lastBat = '0, res;
  expItem_t    it;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_conv(input logic [1:0] s, input logic l);
    expItem_t e;
    e.sel = s; e.low = l;
    expQ.push_back(e);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    @(negedge clk); busAddr = a; #1 v = busRdata;
  endtask

  task automatic waitIdle();
    logic [15:0] v;
    v = 16'hFFFF;
    for (int k = 0; k < 400; k++) begin
      rd(6'h00, v);
      if (v[1:0] == 2'b00) break;
    end
    check("R2 start bits clear on completion", 16'(v[1:0]), 16'h0);
  endtask

  // converter stub and monitor: compares each start against the expected queue
  initial begin
    forever begin
      @(negedge clk);
      if (convStart === 1'b1) begin
        startCnt++;
        if (expQ.size() == 0) begin
          nChk++; nBad++;
          $display("FAIL R5 unexpected start: actual=sel%0d expected=none", convSel);
        end else begin
          it = expQ.pop_front();
          check("R3 R5 channel select order", 16'(convSel), 16'(it.sel));
          check("R4 range flag", 16'(convLowRange), 16'(it.low));
        end
        res = forceEn ? forceVal : {convSel, convLowRange, 9'(stubCnt)};
        stubCnt++;
        if (convSel == 2'd2) lastBat = res; else lastAux = res;
        repeat (stubLat - 1) @(negedge clk);
        convDone = 1'b1; convResult = res;
        @(negedge clk);
        convDone = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int sc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(6'h00, v); check("R1 enable reset", v, 16'h0000);
    rd(6'h04, v); check("R1 config reset", v, 16'h0000);
    rd(6'h08, v); check("R1 mask reset", v, 16'h00FF);
    rd(6'h0C, v); check("R1 status reset", v, 16'h0000);
    rd(6'h1C, v); check("R1 battery result reset", v, 16'h0000);
    rd(6'h20, v); check("R1 aux result reset", v, 16'h0000);
    check("R1 irq reset", 16'(irq), 16'h0);
    check("R1 powerDown reset", 16'(powerDown), 16'h0);

    // R2 R3 aux first input
    wr(6'h04, 16'h0000);
    expect_conv(2'd0, 1'b0);
    wr(6'h00, 16'h0001);
    rd(6'h00, v); check("R2 busy while converting", v, 16'h0001);
    waitIdle();
    rd(6'h20, v); check("R7 aux result", v, {4'h0, lastAux});
    rd(6'h0C, v); check("R8 aux done", v, 16'h0001);
    wr(6'h0C, 16'h0001);
    rd(6'h0C, v); check("R8 w1c aux", v, 16'h0000);

    // R3 second input and non-one select value
    wr(6'h04, 16'h0001); expect_conv(2'd1, 1'b0); wr(6'h00, 16'h0001); waitIdle();
    rd(6'h20, v); check("R3 aux second input result", v, {4'h0, lastAux});
    wr(6'h04, 16'h0002); expect_conv(2'd0, 1'b0); wr(6'h00, 16'h0001); waitIdle();

    // R4 battery ranges, aux ignores range
    wr(6'h04, 16'h0000); expect_conv(2'd2, 1'b0); wr(6'h00, 16'h0002); waitIdle();
    rd(6'h1C, v); check("R7 battery result", v, {4'h0, lastBat});
    wr(6'h04, 16'h0010); expect_conv(2'd2, 1'b1); wr(6'h00, 16'h0002); waitIdle();
    expect_conv(2'd0, 1'b0); wr(6'h00, 16'h0001); waitIdle();
    wr(6'h0C, 16'h0003);

    // R5 both requested: aux then battery
    wr(6'h04, 16'h0001);
    expect_conv(2'd1, 1'b0); expect_conv(2'd2, 1'b0);
    wr(6'h00, 16'h0003);
    waitIdle();
    rd(6'h0C, v); check("R5 R8 both done", v, 16'h0003);
    rd(6'h20, v); check("R5 aux result", v, {4'h0, lastAux});
    rd(6'h1C, v); check("R5 battery result", v, {4'h0, lastBat});

    // R8 selective clear, zero write ignored
    wr(6'h0C, 16'h0002); rd(6'h0C, v); check("R8 clear battery only", v, 16'h0001);
    wr(6'h0C, 16'h0000); rd(6'h0C, v); check("R8 zero write no effect", v, 16'h0001);

    // R9 interrupt masking
    check("R9 all masked", 16'(irq), 16'h0);
    wr(6'h08, 16'h00FE); #1 check("R9 aux unmasked", 16'(irq), 16'h1);
    wr(6'h08, 16'h00FD); #1 check("R9 battery unmasked no flag", 16'(irq), 16'h0);
    wr(6'h08, 16'h00FE); wr(6'h0C, 16'h0001); #1 check("R9 cleared flag", 16'(irq), 16'h0);
    wr(6'h08, 16'h00FF);

    // R6 config change mid-conversion; R2 zero write does not cancel
    stubLat = 20;
    wr(6'h04, 16'h0000);
    expect_conv(2'd0, 1'b0);
    wr(6'h00, 16'h0001);
    wr(6'h04, 16'h0001);
    wr(6'h00, 16'h0000);
    rd(6'h00, v); check("R2 zero write keeps request", v, 16'h0001);
    waitIdle();
    stubLat = 4;
    expect_conv(2'd1, 1'b0); wr(6'h00, 16'h0001); waitIdle();
    rd(6'h0C, v); check("R6 later conversion completed", v, 16'h0001);
    wr(6'h0C, 16'h0003);

    // R10 power down holds off starts
    wr(6'h00, 16'h0080);
    check("R10 powerDown output", 16'(powerDown), 16'h1);
    sc = startCnt;
    wr(6'h00, 16'h0081);
    repeat (30) @(negedge clk);
    check("R10 no start while powered down", 16'(startCnt), 16'(sc));
    rd(6'h00, v); check("R10 request stays pending", v, 16'h0081);
    expect_conv(2'd1, 1'b0);
    wr(6'h00, 16'h0001);
    waitIdle();
    check("R10 runs after release", 16'(startCnt), 16'(sc + 1));
    rd(6'h00, v); check("R10 enable after run", v, 16'h0000);

    // R7 full scale, padding, per-engine hold
    forceEn = 1'b1; forceVal = 12'hFFF;
    expect_conv(2'd1, 1'b0); wr(6'h00, 16'h0001); waitIdle();
    forceEn = 1'b0;
    rd(6'h20, v); check("R7 full scale padded", v, 16'h0FFF);
    wr(6'h04, 16'h0000);
    expect_conv(2'd2, 1'b0); wr(6'h00, 16'h0002); waitIdle();
    rd(6'h20, v); check("R7 aux holds value", v, 16'h0FFF);
    rd(6'h1C, v); check("R7 battery updated", v, {4'h0, lastBat});

    check("R5 all expected starts seen", 16'(expQ.size()), 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule